// File: doc/BRIEF.md
# Coded-Ratio Reference Divider

This block turns a stream of reference-clock tick strobes into a slower stream of comparison pulses for a phase comparator. It does not divide a clock directly: each cycle in which `ref_tick` is high counts as one reference event, and after a selected number of events the block emits a comparison pulse that lasts one clock cycle.

The division ratio comes from a 5-bit select code with a sparse, non-binary encoding. The upper two bits pick a base multiplier of 1, 5, 6 or 7. The lower three bits pick a power-of-two scaling. With a multiplier of 1 the ratio is 2 raised to (low bits + 1). With any other multiplier the ratio is the multiplier shifted left by (low bits − 1). When the low bits are zero and the multiplier is not 1, the code is forbidden. That leaves 29 usable ratios, from 2 up to 448. A forbidden code sets a flag and leaves the divider on the last good ratio. A new code only takes effect at the end of the period in progress. The comparison pulse can also be gated onto a test output.

Top module: `cmp_ratio_divider`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmp_pulse`, `sel_invalid` and `test_out` are low. The first period after reset uses the ratio of the `RESET_CODE` parameter, whatever code is applied. With the default code 00000 that ratio is 2.
- R2: Codes 00000 to 00111 (bits [4:3] = 00) give ratios 2, 4, 8, 16, 32, 64, 128 and 256 in code order.
- R3: Codes 01001 to 01111 give ratios 5, 10, 20, 40, 80, 160 and 320 in code order.
- R4: Codes 10001 to 10111 give ratios 6, 12, 24, 48, 96, 192 and 384 in code order.
- R5: Codes 11001 to 11111 give ratios 7, 14, 28, 56, 112, 224 and 448 in code order.
- R6: The codes 01000, 10000 and 11000 are forbidden. One cycle after such a code is applied, `sel_invalid` is high. The divider keeps producing periods of the last valid ratio.
- R7: A code change made part-way through a period does not alter that period. The new ratio is taken up for the period that starts at the next pulse.
- R8: `cmp_pulse` is high for exactly one clock cycle, the cycle after the clock edge that sampled the terminal tick. Cycles with `ref_tick` low do not advance the count.
- R9: `test_out` equals `cmp_pulse` while `test_en` is high and is low while `test_en` is low.
- R10: One cycle after a valid code is applied again, `sel_invalid` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One reference event per cycle when high |
| ratio_sel | input | 5 | Division ratio select code |
| test_en | input | 1 | Routes the comparison pulse to `test_out` |
| cmp_pulse | output | 1 | One-cycle comparison pulse |
| sel_invalid | output | 1 | Registered flag: applied code is forbidden |
| test_out | output | 1 | Gated copy of the comparison pulse |

## Verification
The assertions assume the following about the inputs:
- Every ratio is at least 2, so two comparison pulses can never fall in adjacent cycles.
- A pulse is always preceded by a sampled tick.
- The number of ticks between pulses never exceeds 448.

All of these hold only if `ratio_sel` changes are presented synchronously and `ref_tick` is a clean one-cycle-per-event strobe. The stimulus meets this by changing every input just after a rising edge. Ticks are applied both back-to-back and with idle cycles between them, and codes are changed both exactly at pulse boundaries and in the middle of a period.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    localparam int SEL_W     = 5;
    localparam int RATIO_MAX = 448;

    typedef struct packed {
        logic       ok;
        logic [8:0] ratio;
    } ratio_word_t;

    // Multiplier chosen by the upper two code bits.
    function automatic int base_mult(input logic [1:0] fam);
        case (fam)
            2'd0:    return 1;
            2'd1:    return 5;
            2'd2:    return 6;
            default: return 7;
        endcase
    endfunction

    function automatic logic code_ok(input logic [SEL_W-1:0] c);
        return !(c[4:3] != 2'd0 && c[2:0] == 3'd0);
    endfunction

    // Ratio for a code; 0 for forbidden codes.
    function automatic int code_ratio(input logic [SEL_W-1:0] c);
        int e;
        e = int'(c[2:0]);
        if (c[4:3] == 2'd0)
            return 2 << e;
        else if (e == 0)
            return 0;
        else
            return base_mult(c[4:3]) << (e - 1);
    endfunction

endpackage

// File: rtl/rdiv_decode.sv
module rdiv_decode
    import rdiv_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic [SEL_W-1:0] code,
    output logic             ok,
    output logic [CNT_W-1:0] ratio
);

    always_comb begin
        ok    = code_ok(code);
        ratio = CNT_W'(code_ratio(code));
    end

endmodule

// File: rtl/rdiv_counter.sv
module rdiv_counter #(
    parameter int CNT_W       = 9,
    parameter int RESET_RATIO = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] next_ratio,
    output logic             pulse
);

    localparam logic [CNT_W-1:0] RST_R = CNT_W'(RESET_RATIO);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] active;
    logic             terminal;

    assign terminal = (cnt == active - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= RST_R;
            pulse  <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (terminal) begin
                    cnt    <= '0;
                    pulse  <= 1'b1;
                    active <= next_ratio;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/cmp_ratio_divider.sv
module cmp_ratio_divider
    import rdiv_pkg::*;
#(
    parameter int              CNT_W      = $clog2(RATIO_MAX + 1),
    parameter logic [SEL_W-1:0] RESET_CODE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             test_en,
    output logic             cmp_pulse,
    output logic             sel_invalid,
    output logic             test_out
);

    localparam int RESET_RATIO = code_ratio(RESET_CODE);

    logic             dec_ok;
    logic [CNT_W-1:0] dec_ratio;
    logic [CNT_W-1:0] held_ratio;
    logic [CNT_W-1:0] next_ratio;

    rdiv_decode #(.CNT_W(CNT_W)) u_dec (
        .code  (ratio_sel),
        .ok    (dec_ok),
        .ratio (dec_ratio)
    );

    // Last valid ratio seen; forbidden codes leave it untouched.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_ratio  <= CNT_W'(RESET_RATIO);
            sel_invalid <= 1'b0;
        end else begin
            sel_invalid <= !dec_ok;
            if (dec_ok)
                held_ratio <= dec_ratio;
        end
    end

    assign next_ratio = dec_ok ? dec_ratio : held_ratio;

    rdiv_counter #(.CNT_W(CNT_W), .RESET_RATIO(RESET_RATIO)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (ref_tick),
        .next_ratio (next_ratio),
        .pulse      (cmp_pulse)
    );

    assign test_out = test_en & cmp_pulse;

endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker
    import rdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ref_tick,
    input logic [SEL_W-1:0] ratio_sel,
    input logic             test_en,
    input logic             cmp_pulse,
    input logic             sel_invalid,
    input logic             test_out
);

    int unsigned ticks_since;

    always_ff @(posedge clk) begin
        if (rst)
            ticks_since <= 0;
        else if (cmp_pulse)
            ticks_since <= ref_tick ? 1 : 0;
        else if (ref_tick)
            ticks_since <= ticks_since + 1;
    end

    // R8: one-cycle pulse, always caused by a sampled tick
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |=> !cmp_pulse);
    a_r8_after_tick: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> $past(ref_tick));
    // R2-R5: period stays within the ratio range
    a_r5_period_bound: assert property (@(posedge clk) disable iff (rst)
        ticks_since <= RATIO_MAX);
    a_r2_period_min: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> ticks_since >= 2);
    // R6 / R10: flag tracks the previously applied code
    a_r6_flag_forbidden: assert property (@(posedge clk) disable iff (rst)
        sel_invalid |-> $past(ratio_sel[4:3] != 2'd0 && ratio_sel[2:0] == 3'd0));
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
        $past(ratio_sel[2:0] != 3'd0) |-> !sel_invalid);
    // R9: test routing
    a_r9_gate_off: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> !test_out);
    a_r9_gate_on: assert property (@(posedge clk) disable iff (rst)
        (test_en && cmp_pulse) |-> test_out);

endmodule

bind cmp_ratio_divider rdiv_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_tick    (ref_tick),
    .ratio_sel   (ratio_sel),
    .test_en     (test_en),
    .cmp_pulse   (cmp_pulse),
    .sel_invalid (sel_invalid),
    .test_out    (test_out)
);

// File: tb/cmp_ratio_divider_test.sv
module cmp_ratio_divider_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic [4:0] ratio_sel = 5'b0;
    logic       test_en = 1'b0;
    logic       cmp_pulse;
    logic       sel_invalid;
    logic       test_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmp_ratio_divider uut (
        .clk         (clk),
        .rst         (rst),
        .ref_tick    (ref_tick),
        .ratio_sel   (ratio_sel),
        .test_en     (test_en),
        .cmp_pulse   (cmp_pulse),
        .sel_invalid (sel_invalid),
        .test_out    (test_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive tick level, read outputs just after the edge.
    task automatic step(input logic t, output logic p);
        ref_tick = t;
        @(posedge clk);
        #1;
        p = cmp_pulse;
        ref_tick = 1'b0;
    endtask

    // Ticks until a pulse appears; gap idle cycles between ticks.
    task automatic period(input int gap, output int n);
        logic p;
        n = 0;
        p = 1'b0;
        while (!p && n < 600) begin
            for (int g = 0; g < gap; g++) begin
                step(1'b0, p);
                if (p) n = 9999;
            end
            step(1'b1, p);
            n++;
        end
    endtask

    function automatic int expect_ratio(input logic [4:0] c);
        int m;
        case (c[4:3])
            2'd0: m = 1;
            2'd1: m = 5;
            2'd2: m = 6;
            default: m = 7;
        endcase
        if (m == 1) return 2 << c[2:0];
        return m << (c[2:0] - 1);
    endfunction

    task automatic t_reset;
        int n;
        ratio_sel = 5'b00011;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(cmp_pulse == 0 && sel_invalid == 0 && test_out == 0, "R1 outputs in reset", cmp_pulse, 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(cmp_pulse == 0 && sel_invalid == 0, "R1 outputs after reset", cmp_pulse, 0);
        period(0, n);
        check(n == 2, "R1 first period uses reset ratio", n, 2);
        period(0, n);
        check(n == 16, "R2 code 00011 after first pulse", n, 16);
    endtask

    task automatic t_family(input logic [1:0] fam, input string req);
        int n;
        for (int e = 0; e < 8; e++) begin
            if (fam != 0 && e == 0) continue;
            ratio_sel = {fam, 3'(e)};
            period(0, n);
            period(e % 2, n);
            check(n == expect_ratio(ratio_sel), req, n, expect_ratio(ratio_sel));
        end
    endtask

    task automatic t_pulse_width;
        logic p;
        int n;
        ratio_sel = 5'b00001;
        period(0, n);
        period(2, n);
        check(n == 4, "R8 idle cycles do not count", n, 4);
        step(1'b0, p);
        check(p == 0, "R8 pulse lasts one cycle", p, 0);
    endtask

    task automatic t_midchange;
        int n, m;
        logic p;
        ratio_sel = 5'b00010;
        period(0, n);
        for (int i = 0; i < 3; i++) step(1'b1, p);
        ratio_sel = 5'b01001;
        period(0, m);
        check(m + 3 == 8, "R7 running period keeps old ratio", m + 3, 8);
        period(0, n);
        check(n == 5, "R7 new ratio at boundary", n, 5);
    endtask

    task automatic t_forbidden(input logic [4:0] bad);
        int n;
        logic p;
        ratio_sel = 5'b01001;
        period(0, n);
        period(0, n);
        ratio_sel = bad;
        step(1'b0, p);
        check(sel_invalid == 1, "R6 flag on forbidden code", sel_invalid, 1);
        period(0, n);
        check(n == 5, "R6 ratio held", n, 5);
        period(1, n);
        check(n == 5, "R6 ratio still held", n, 5);
        ratio_sel = 5'b00001;
        step(1'b0, p);
        check(sel_invalid == 0, "R10 flag clears", sel_invalid, 0);
        period(0, n);
        period(0, n);
        check(n == 4, "R10 new valid ratio used", n, 4);
    endtask

    task automatic t_testport;
        int n;
        logic p;
        ratio_sel = 5'b00000;
        test_en = 1'b1;
        period(0, n);
        period(0, n);
        check(test_out == 1, "R9 test_out follows pulse", test_out, 1);
        step(1'b0, p);
        check(test_out == 0, "R9 test_out low between pulses", test_out, 0);
        test_en = 1'b0;
        period(0, n);
        check(test_out == 0 && cmp_pulse == 1, "R9 test_out gated off", test_out, 0);
    endtask

    initial begin
        t_reset();
        t_pulse_width();
        t_family(2'd0, "R2 ratio");
        t_family(2'd1, "R3 ratio");
        t_family(2'd2, "R4 ratio");
        t_family(2'd3, "R5 ratio");
        t_midchange();
        t_forbidden(5'b01000);
        t_forbidden(5'b10000);
        t_forbidden(5'b11000);
        t_testport();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule